// File: doc/BRIEF.md
# SCSI command decode sequencer

This block sits behind the command register of a SCSI host controller. Each byte written to the command offset is decoded into one high-level operation: target selection (plain, with attention, or with attention and a stop before the command phase), information transfer, initiator completion, message acceptance, transfer padding, FIFO flush, bus reset, enable-selection, no-op and chip reset. For each operation the sequencer leaves a defined combination of bus phase and flag bits in the status register, an interrupt cause code and a sequence step, and it drives the interrupt line.

Target presence, the phase a target reports and the number of data bytes it still has come from a small target-status input group. The block presents the selected bus ID to that group. Memory transfers go through a request/length/done handshake. The length comes from a 16-bit transfer counter, where a count of zero means 65536. Selections issued while the DMA channel is disabled wait until the enable input is high. A status-register read strobe clears the interrupt cause and lowers the interrupt line.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After reset, and after command opcode 0x02 (chip reset), all of the following are zero: status, interrupt cause, sequence step, flags, live counter, interrupt line, DMA request and the error pulse. The config quiet bit is also clear. Status bit 7 always reads as the interrupt line.
- R2: Writes to offset 0 store the low counter byte and writes to offset 1 store the high counter byte. Either write clears status bit 4. A command byte with bit 7 set copies the stored counter into the live counter. Bit 7 clear leaves the live counter unchanged.
- R3: Opcodes 0x41 and 0x42, issued with DMA enabled, select the target whose ID is the low 3 bits of the offset-4 register. If that target is absent: status 0x00, cause 0x20, step 0, interrupt raised. If it is present: status 0x10 OR the reported phase, cause 0x18, step 4, interrupt raised.
- R4: Opcode 0x43 behaves like R3 when the target is absent. When the target is present it sets status 0x12, cause 0x18 and step 4, raises the interrupt and enters command-collect mode.
- R5: A selection opcode written while DMA enable is low changes nothing. It runs, with the target present at that time, in the first cycle that enable is high, and its effects appear on the next cycle.
- R6: Opcode 0x10 computes a length from the live counter (after any reload), with 0 meaning 65536. The length is capped at 32 in command-collect mode and otherwise at the target's remaining byte count. With bit 7 set and a non-zero length, it raises the DMA request with that length and clears status bit 4. With bit 7 clear in command-collect mode, it leaves collect mode and sets status 0x10 OR phase, cause 0x18 and step 4, and raises the interrupt.
- R7: DMA completion happens on done while a request is pending, or at once for a DMA transfer of length 0. It sets status bit 4, cause 0x10, step 0, flags 0 and counter 0, raises the interrupt, drops the request and leaves collect mode.
- R8: Opcode 0x01 sets cause 0x08, step 0 and flags 0. Opcode 0x18 sets status 0x10, cause 0x08 and step 0. Neither opcode changes the interrupt line.
- R9: Opcode 0x03 sets cause 0x80. It raises the interrupt only when bit 6 of the offset-8 config register is clear.
- R10: Opcode 0x12 sets cause 0x20, step 0 and flags 0, and raises the interrupt. Opcode 0x44 clears the cause.
- R11: Opcode 0x11 sets cause 0x08 and raises the interrupt. With bit 7 set, status becomes 0x17 and step 4. With bit 7 clear, status bits 2:0 become 7 and flags becomes 2.
- R12: An unknown opcode pulses the error output for one cycle and changes nothing else. Opcodes 0x00 and 0x1A change nothing.
- R13: The cause-read strobe sets cause 0, clears status bit 4, sets step 4 and lowers the interrupt. Updates from a DMA completion, a pending selection or a command write in the same cycle are applied after it, in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register offset |
| wr_data_i | input | 8 | Write data |
| cause_rd_i | input | 1 | Interrupt cause register is being read |
| dma_en_i | input | 1 | DMA channel enable |
| dma_done_i | input | 1 | DMA engine finished the requested transfer |
| tgt_present_i | input | 1 | A target answers at tgt_id_o |
| tgt_phase_i | input | 3 | Bus phase reported by the target |
| tgt_avail_i | input | 17 | Data bytes the target still has |
| tgt_id_o | output | 3 | Selected target ID |
| status_o | output | 8 | Status register (bit 7 = interrupt) |
| cause_o | output | 8 | Interrupt cause |
| seq_o | output | 3 | Sequence step |
| flags_o | output | 8 | Flags register |
| count_o | output | 16 | Live transfer counter |
| irq_o | output | 1 | Interrupt line |
| dma_req_o | output | 1 | DMA transfer request |
| dma_len_o | output | 17 | Requested DMA length |
| err_o | output | 1 | One-cycle pulse on an unknown opcode |

## Verification
Two cases of same-cycle overlap are exercised. In the first, the cause-read strobe arrives in the same cycle as a command write: it is asserted together with a bus-reset write, and the next cycle must show cause 0x80 with the interrupt still high. In the second, it arrives in the same cycle as a DMA done: the next cycle must show the completion cause 0x10 rather than a cleared cause. A behavioural model in the bench applies the clear first, then completion, then pending selection, then the command, and every output is compared against it on every cycle.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

    localparam logic [3:0] A_CNT_LO  = 4'h0;
    localparam logic [3:0] A_CNT_HI  = 4'h1;
    localparam logic [3:0] A_CMD     = 4'h3;
    localparam logic [3:0] A_BUSID   = 4'h4;
    localparam logic [3:0] A_CFG     = 4'h8;

    localparam logic [7:0] C_DISC    = 8'h20;
    localparam logic [7:0] C_SELDONE = 8'h18;
    localparam logic [7:0] C_FUNC    = 8'h08;
    localparam logic [7:0] C_BUSRST  = 8'h80;
    localparam logic [7:0] C_SVC     = 8'h10;

    localparam int QUIET_BIT = 6;

    typedef enum logic [3:0] {
        K_NOP, K_FLUSH, K_CHIPRST, K_BUSRST, K_XFER, K_CPLSEQ, K_MSGOK,
        K_PAD, K_SEL, K_SELSTOP, K_ENSEL, K_BAD
    } op_kind_e;

endpackage

// File: rtl/seq_opdec.sv
module seq_opdec
    import scsi_seq_pkg::*;
(
    input  logic [6:0] op_i,
    output op_kind_e   kind_o
);
    always_comb begin
        case (op_i)
            7'h00, 7'h1A: kind_o = K_NOP;
            7'h01:        kind_o = K_FLUSH;
            7'h02:        kind_o = K_CHIPRST;
            7'h03:        kind_o = K_BUSRST;
            7'h10:        kind_o = K_XFER;
            7'h11:        kind_o = K_CPLSEQ;
            7'h12:        kind_o = K_MSGOK;
            7'h18:        kind_o = K_PAD;
            7'h41, 7'h42: kind_o = K_SEL;
            7'h43:        kind_o = K_SELSTOP;
            7'h44:        kind_o = K_ENSEL;
            default:      kind_o = K_BAD;
        endcase
    end
endmodule

// File: rtl/seq_xfer_len.sv
module seq_xfer_len #(
    parameter int CNT_W   = 16,
    parameter int CMD_MAX = 32
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             collect_i,
    input  logic [CNT_W:0]   avail_i,
    output logic [CNT_W:0]   len_o
);
    localparam logic [CNT_W:0] CAP = (CNT_W+1)'(CMD_MAX);

    logic [CNT_W:0] full_cnt;
    logic [CNT_W:0] limit;

    always_comb begin
        full_cnt = (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
        limit    = collect_i ? CAP : avail_i;
        len_o    = (full_cnt < limit) ? full_cnt : limit;
    end
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
    import scsi_seq_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CMD_MAX = 32,
    parameter int ID_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [3:0]       wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic             cause_rd_i,
    input  logic             dma_en_i,
    input  logic             dma_done_i,
    input  logic             tgt_present_i,
    input  logic [2:0]       tgt_phase_i,
    input  logic [CNT_W:0]   tgt_avail_i,
    output logic [ID_W-1:0]  tgt_id_o,
    output logic [7:0]       status_o,
    output logic [7:0]       cause_o,
    output logic [2:0]       seq_o,
    output logic [7:0]       flags_o,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_o,
    output logic             dma_req_o,
    output logic [CNT_W:0]   dma_len_o,
    output logic             err_o
);
    localparam int HI_W = CNT_W - 8;

    typedef struct packed {
        logic [6:0]       status;
        logic [7:0]       cause;
        logic [2:0]       seq;
        logic [7:0]       flags;
        logic [CNT_W-1:0] cnt_wr;
        logic [CNT_W-1:0] cnt;
        logic [ID_W-1:0]  busid;
        logic             quiet;
        logic             irq;
        logic             collect;
        logic             pend;
        logic             pstop;
        logic             req;
        logic [CNT_W:0]   len;
        logic             err;
    } state_t;

    localparam state_t RST_VAL = '0;

    state_t   st_q, st_d;
    op_kind_e kind;
    logic     wr_cmd;
    logic [CNT_W:0]   xfer_len;
    logic [CNT_W-1:0] len_cnt;

    seq_opdec u_dec (
        .op_i   (wr_data_i[6:0]),
        .kind_o (kind)
    );

    assign len_cnt = wr_data_i[7] ? st_q.cnt_wr : st_q.cnt;

    seq_xfer_len #(.CNT_W(CNT_W), .CMD_MAX(CMD_MAX)) u_len (
        .cnt_i     (len_cnt),
        .collect_i (st_q.collect),
        .avail_i   (tgt_avail_i),
        .len_o     (xfer_len)
    );

    function automatic state_t finish_dma(input state_t s);
        state_t r = s;
        r.status[4] = 1'b1;
        r.cause     = C_SVC;
        r.seq       = 3'd0;
        r.flags     = 8'h00;
        r.cnt       = '0;
        r.irq       = 1'b1;
        r.req       = 1'b0;
        r.collect   = 1'b0;
        return r;
    endfunction

    function automatic state_t run_select(input state_t s, input logic stop,
                                          input logic present, input logic [2:0] ph);
        state_t r = s;
        r.irq = 1'b1;
        if (!present) begin
            r.status = 7'h00;
            r.cause  = C_DISC;
            r.seq    = 3'd0;
        end else begin
            r.cause = C_SELDONE;
            r.seq   = 3'd4;
            if (stop) begin
                r.collect = 1'b1;
                r.status  = 7'h12;
            end else begin
                r.status  = 7'h10 | {4'b0, ph};
            end
        end
        return r;
    endfunction

    assign wr_cmd = wr_en_i && (wr_addr_i == A_CMD);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (cause_rd_i) begin
            st_d.cause     = 8'h00;
            st_d.status[4] = 1'b0;
            st_d.seq       = 3'd4;
            st_d.irq       = 1'b0;
        end
        if (st_q.req && dma_done_i) st_d = finish_dma(st_d);
        if (st_q.pend && dma_en_i) begin
            st_d      = run_select(st_d, st_q.pstop, tgt_present_i, tgt_phase_i);
            st_d.pend = 1'b0;
        end
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CNT_LO: begin
                    st_d.cnt_wr[7:0] = wr_data_i;
                    st_d.status[4]   = 1'b0;
                end
                A_CNT_HI: begin
                    st_d.cnt_wr[CNT_W-1:8] = wr_data_i[HI_W-1:0];
                    st_d.status[4]         = 1'b0;
                end
                A_BUSID: st_d.busid = wr_data_i[ID_W-1:0];
                A_CFG:   st_d.quiet = wr_data_i[QUIET_BIT];
                default: ;
            endcase
        end
        if (wr_cmd) begin
            if (wr_data_i[7]) st_d.cnt = st_q.cnt_wr;
            case (kind)
                K_FLUSH: begin
                    st_d.cause = C_FUNC;
                    st_d.seq   = 3'd0;
                    st_d.flags = 8'h00;
                end
                K_CHIPRST: st_d = RST_VAL;
                K_BUSRST: begin
                    st_d.cause = C_BUSRST;
                    if (!st_q.quiet) st_d.irq = 1'b1;
                end
                K_XFER: begin
                    if (wr_data_i[7]) begin
                        if (xfer_len == '0) begin
                            st_d = finish_dma(st_d);
                        end else begin
                            st_d.req       = 1'b1;
                            st_d.len       = xfer_len;
                            st_d.status[4] = 1'b0;
                        end
                    end else if (st_q.collect) begin
                        st_d.collect = 1'b0;
                        st_d.status  = 7'h10 | {4'b0, tgt_phase_i};
                        st_d.cause   = C_SELDONE;
                        st_d.seq     = 3'd4;
                        st_d.irq     = 1'b1;
                    end
                end
                K_CPLSEQ: begin
                    st_d.cause = C_FUNC;
                    st_d.irq   = 1'b1;
                    if (wr_data_i[7]) begin
                        st_d.status = 7'h17;
                        st_d.seq    = 3'd4;
                    end else begin
                        st_d.status[2:0] = 3'd7;
                        st_d.flags       = 8'h02;
                    end
                end
                K_MSGOK: begin
                    st_d.cause = C_DISC;
                    st_d.seq   = 3'd0;
                    st_d.flags = 8'h00;
                    st_d.irq   = 1'b1;
                end
                K_PAD: begin
                    st_d.status = 7'h10;
                    st_d.cause  = C_FUNC;
                    st_d.seq    = 3'd0;
                end
                K_SEL, K_SELSTOP: begin
                    if (dma_en_i) begin
                        st_d = run_select(st_d, kind == K_SELSTOP, tgt_present_i, tgt_phase_i);
                    end else begin
                        st_d.pend  = 1'b1;
                        st_d.pstop = (kind == K_SELSTOP);
                    end
                end
                K_ENSEL: st_d.cause = 8'h00;
                K_BAD:   st_d.err   = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign tgt_id_o  = st_q.busid;
    assign status_o  = {st_q.irq, st_q.status};
    assign cause_o   = st_q.cause;
    assign seq_o     = st_q.seq;
    assign flags_o   = st_q.flags;
    assign count_o   = st_q.cnt;
    assign irq_o     = st_q.irq;
    assign dma_req_o = st_q.req;
    assign dma_len_o = st_q.len;
    assign err_o     = st_q.err;

    // R6: a new request never asks for zero bytes nor more than a full count
    assert_req_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_o) |-> (dma_len_o != '0) && (dma_len_o <= {1'b1, {CNT_W{1'b0}}}));

    // R7: completion without a competing update posts the service cause
    assert_done_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req_o && dma_done_i && !wr_cmd && !(st_q.pend && dma_en_i))
        |=> (irq_o && cause_o == C_SVC && !dma_req_o));

    // R5: a pending selection is consumed once enable is high
    assert_pend_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && dma_en_i) |=> !st_q.pend);

    // R12: the error pulse only follows a command write
    assert_err_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($past(wr_en_i) && $past(wr_addr_i) == A_CMD));

    // R13: a lone cause read drops the interrupt and the cause
    assert_rd_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_rd_i && !wr_cmd && !(dma_req_o && dma_done_i) && !(st_q.pend && dma_en_i))
        |=> (!irq_o && cause_o == 8'h00 && seq_o == 3'd4));

endmodule

// File: tb/scsi_cmd_seq_bench.sv
module scsi_cmd_seq_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [3:0]  wr_addr = 0;
    logic [7:0]  wr_data = 0;
    logic        cause_rd = 0;
    logic        dma_en = 1;
    logic        dma_done = 0;
    logic        tgt_present;
    logic [2:0]  tgt_phase = 3'd1;
    logic [16:0] tgt_avail = 17'd0;
    logic [7:0]  present_mask = 8'b0000_0100;

    logic [2:0]  tgt_id;
    logic [7:0]  status, cause, flags;
    logic [2:0]  seq;
    logic [15:0] count;
    logic        irq, dma_req, err;
    logic [16:0] dma_len;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [6:0]  m_status;
    logic [7:0]  m_cause, m_flags;
    logic [2:0]  m_seq, m_busid;
    logic [15:0] m_cntwr, m_cnt;
    logic        m_quiet, m_irq, m_collect, m_pend, m_pstop, m_req, m_err;
    int          m_len;

    always #10 clk = ~clk;

    assign tgt_present = present_mask[tgt_id];

    scsi_cmd_seq u_scsi_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .cause_rd_i(cause_rd), .dma_en_i(dma_en),
        .dma_done_i(dma_done), .tgt_present_i(tgt_present),
        .tgt_phase_i(tgt_phase), .tgt_avail_i(tgt_avail), .tgt_id_o(tgt_id),
        .status_o(status), .cause_o(cause), .seq_o(seq), .flags_o(flags),
        .count_o(count), .irq_o(irq), .dma_req_o(dma_req),
        .dma_len_o(dma_len), .err_o(err)
    );

    task automatic chk(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    task automatic m_reset();
        m_status = 0; m_cause = 0; m_flags = 0; m_seq = 0; m_busid = 0;
        m_cntwr = 0; m_cnt = 0; m_quiet = 0; m_irq = 0; m_collect = 0;
        m_pend = 0; m_pstop = 0; m_req = 0; m_err = 0; m_len = 0;
    endtask

    task automatic m_finish();
        m_status[4] = 1; m_cause = 8'h10; m_seq = 0; m_flags = 0; m_cnt = 0;
        m_irq = 1; m_req = 0; m_collect = 0;
    endtask

    task automatic m_select(logic stop);
        m_irq = 1;
        if (!present_mask[m_busid]) begin
            m_status = 0; m_cause = 8'h20; m_seq = 0;
        end else if (stop) begin
            m_collect = 1; m_status = 7'h12; m_cause = 8'h18; m_seq = 4;
        end else begin
            m_status = 7'h10 | 7'(tgt_phase); m_cause = 8'h18; m_seq = 4;
        end
    endtask

    task automatic model_step();
        logic oc, oq, oreq;
        logic [15:0] ocnt, ocw, src;
        int full, lim, len;
        oc = m_collect; oq = m_quiet; oreq = m_req; ocnt = m_cnt; ocw = m_cntwr;
        m_err = 0;
        if (cause_rd) begin m_cause = 0; m_status[4] = 0; m_seq = 4; m_irq = 0; end
        if (oreq && dma_done) m_finish();
        if (m_pend && dma_en) begin m_select(m_pstop); m_pend = 0; end
        if (wr_en) begin
            if (wr_addr == 0) begin m_cntwr[7:0] = wr_data; m_status[4] = 0; end
            else if (wr_addr == 1) begin m_cntwr[15:8] = wr_data; m_status[4] = 0; end
            else if (wr_addr == 4) m_busid = wr_data[2:0];
            else if (wr_addr == 8) m_quiet = wr_data[6];
            else if (wr_addr == 3) begin
                src  = wr_data[7] ? ocw : ocnt;
                full = (src == 0) ? 65536 : int'(src);
                lim  = oc ? 32 : int'(tgt_avail);
                len  = (full < lim) ? full : lim;
                if (wr_data[7]) m_cnt = ocw;
                case (wr_data[6:0])
                    7'h00, 7'h1A: ;
                    7'h01: begin m_cause = 8'h08; m_seq = 0; m_flags = 0; end
                    7'h02: m_reset();
                    7'h03: begin m_cause = 8'h80; if (!oq) m_irq = 1; end
                    7'h10: begin
                        if (wr_data[7]) begin
                            if (len == 0) m_finish();
                            else begin m_req = 1; m_len = len; m_status[4] = 0; end
                        end else if (oc) begin
                            m_collect = 0; m_status = 7'h10 | 7'(tgt_phase);
                            m_cause = 8'h18; m_seq = 4; m_irq = 1;
                        end
                    end
                    7'h11: begin
                        m_cause = 8'h08; m_irq = 1;
                        if (wr_data[7]) begin m_status = 7'h17; m_seq = 4; end
                        else begin m_status[2:0] = 3'd7; m_flags = 8'h02; end
                    end
                    7'h12: begin m_cause = 8'h20; m_seq = 0; m_flags = 0; m_irq = 1; end
                    7'h18: begin m_status = 7'h10; m_cause = 8'h08; m_seq = 0; end
                    7'h41, 7'h42, 7'h43: begin
                        if (dma_en) m_select(wr_data[6:0] == 7'h43);
                        else begin m_pend = 1; m_pstop = (wr_data[6:0] == 7'h43); end
                    end
                    7'h44: m_cause = 0;
                    default: m_err = 1;
                endcase
            end
        end
    endtask

    task automatic compare_all();
        chk("status", status, {m_irq, m_status});
        chk("cause", cause, m_cause);
        chk("seq", seq, m_seq);
        chk("flags", flags, m_flags);
        chk("count", count, m_cnt);
        chk("irq", irq, m_irq);
        chk("dma_req", dma_req, m_req);
        if (m_req) chk("dma_len", dma_len, m_len);
        chk("err", err, m_err);
        chk("tgt_id", tgt_id, m_busid);
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic rdc();
        cause_rd = 1; cyc(); cause_rd = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_tag = "R1"; compare_all(); idle(1);

        cur_tag = "R2";
        wr(0, 8'h05); wr(1, 8'h00);
        wr(3, 8'h00); chk("count after plain cmd R2", count, 0);
        wr(3, 8'h80); chk("count after reload R2", count, 16'h0005);

        cur_tag = "R9";
        wr(4, 8'h02);
        wr(3, 8'h03); chk("busrst irq R9", irq, 1);
        rdc();
        wr(8, 8'h40); wr(3, 8'h03); chk("quiet busrst irq R9", irq, 0);
        wr(8, 8'h07);

        cur_tag = "R3";
        wr(4, 8'h05); wr(3, 8'h42); chk("absent cause R3", cause, 8'h20);
        rdc();
        wr(4, 8'h02); tgt_phase = 3'd1; wr(3, 8'h41); chk("present status R3", status, 8'h91);
        rdc();

        cur_tag = "R4";
        wr(3, 8'h43); chk("stop status R4", status, 8'h92);
        rdc();
        cur_tag = "R6"; tgt_phase = 3'd3;
        wr(3, 8'h10); chk("collect ends R6", status, 8'h93);
        rdc();

        cur_tag = "R6";
        tgt_avail = 17'h20; wr(0, 8'h40); wr(1, 8'h00);
        wr(3, 8'h90); chk("capped len R6", dma_len, 17'h20);
        idle(2);
        cur_tag = "R7"; dma_done = 1; cyc(); dma_done = 0;
        chk("done cause R7", cause, 8'h10);
        rdc();
        cur_tag = "R6"; tgt_avail = 17'h1FFFF; wr(0, 8'h00);
        wr(3, 8'h90); chk("zero means 65536 R6", dma_len, 17'h10000);
        cur_tag = "R13"; dma_done = 1; cause_rd = 1; cyc(); dma_done = 0; cause_rd = 0;
        chk("done after read R13", cause, 8'h10);
        cur_tag = "R6"; wr(3, 8'h43); wr(1, 8'h01); wr(3, 8'h90);
        chk("collect cap R6", dma_len, 17'd32);
        cur_tag = "R7"; dma_done = 1; cyc(); dma_done = 0;
        tgt_avail = 0; wr(3, 8'h90); chk("zero length completes R7", dma_req, 0);
        rdc();

        cur_tag = "R5";
        dma_en = 0; wr(3, 8'h41); idle(2); chk("held R5", irq, 0);
        dma_en = 1; cyc(); chk("released R5", cause, 8'h18);
        rdc();

        cur_tag = "R8";
        wr(3, 8'h01); chk("flush cause R8", cause, 8'h08);
        wr(3, 8'h18); chk("pad status R8", status, 8'h10);

        cur_tag = "R10";
        wr(3, 8'h12); chk("msgok R10", cause, 8'h20);
        wr(3, 8'h44); chk("ensel R10", cause, 8'h00);
        rdc();

        cur_tag = "R11";
        wr(3, 8'h91); chk("cpl dma R11", status, 8'h97);
        rdc();
        wr(3, 8'h11); chk("cpl pio flags R11", flags, 8'h02);
        rdc();

        cur_tag = "R12";
        wr(3, 8'h7F); chk("bad err R12", err, 1);
        cyc(); chk("err one cycle R12", err, 0);
        wr(3, 8'h1A);

        cur_tag = "R13";
        wr(3, 8'h12);
        cause_rd = 1; wr(3, 8'h03); cause_rd = 0;
        chk("cmd wins R13", cause, 8'h80);
        rdc(); chk("read clears R13", irq, 0);

        cur_tag = "R1";
        wr(3, 8'h43); wr(0, 8'h33);
        wr(3, 8'h02); chk("chip reset R1", status, 8'h00);
        idle(2);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule